// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block watches a processor's instruction stream and its data accesses for addresses that software has marked as interesting. It holds four slot address registers, a control word and a status word. The control word gives each slot an enable, a match type and a watch length. Every cycle in which an instruction pointer or a data access is presented counts as a check. On a check, each slot is compared against the instruction pointer or the access, depending on its type.

A check builds a fresh hit pattern in the low status bits. The pattern records the result of every slot, including slots that are disabled. The pattern is written to the status word only when an enabled slot hit or the force input was high. When an enabled slot hit, a one-cycle exception request follows. Software loads the registers through a single write port. The status word is visible at all times on an output.

Top module: `dbg_match_unit`

## Requirements
- R1: While reset is asserted and right after it, `status` reads 0 and `dbgExc` reads 0.
- R2: A write with `regWrEn` high loads the register chosen by `regWrSel`. Select 0 to 3 picks slot address 0 to 3, select 4 picks the control word and select 5 picks the status word. If a status write falls in the same cycle as a status commit, the commit wins.
- R3: A slot whose type field is 00 (execute) hits when `ipValid` is high and `ipAddr` equals the slot address.
- R4: Type 01 (write watch) hits only on a data access with `dataWrite` high. Type 11 (read/write watch) hits on any data access. Type 10 (I/O) never hits.
- R5: A data slot watches the range that starts at its address aligned down to the watch length and spans that length. The watch length is given by the length field: 00 is 1 byte, 01 is 2 bytes, 11 is 4 bytes and 10 is 8 bytes. The access spans `dataSize` bytes from `dataAddr`, with 00, 01, 10 and 11 meaning 1, 2, 4 and 8 bytes. The slot hits when the two ranges overlap.
- R6: When a check commits, `status[3:0]` becomes the hit pattern of all four slots, enabled or not, with bit n for slot n. The upper status bits keep their value.
- R7: A check commits only if an enabled slot hit or `forceUpd` is high. Otherwise `status` is unchanged.
- R8: `dbgExc` is high in the cycle after a check in which an enabled slot hit, and low after every other cycle.
- R9: In the control word, slot n is enabled by bit 2n or bit 2n+1. Its type sits at bits 16+4n..17+4n and its length field at bits 18+4n..19+4n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 3 | Register select (0-3 slot address, 4 control, 5 status) |
| regWrData | input | 32 | Register write data |
| ipValid | input | 1 | Instruction pointer valid |
| ipAddr | input | 32 | Current instruction pointer |
| dataValid | input | 1 | Data access valid |
| dataAddr | input | 32 | Data access start address |
| dataWrite | input | 1 | 1 for a write access, 0 for a read |
| dataSize | input | 2 | Access size code (1/2/4/8 bytes) |
| forceUpd | input | 1 | Commit the hit pattern even without an enabled hit |
| status | output | 32 | Status word, low four bits hold slot hits |
| dbgExc | output | 1 | Debug exception request pulse |

## Verification
Every slot is tried with an execute match under all four enable combinations. This separates the local and global enable bits and shows that disabled hits leave the status word untouched. A near-match pointer and an invalid pointer confirm that equality and the valid strobe both matter. Each type code is tried against reads, writes and instruction pointers, which tells the write watch apart from the read/write watch and keeps I/O silent. A sweep of access addresses over every watch length and access size, compared with an arithmetic overlap model, catches alignment and range-end errors. Forced updates, mixed enabled and disabled hits, preserved upper status bits and a status write that collides with a commit cover the commit rules.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

  typedef enum logic [1:0] {
    BK_EXEC  = 2'b00,
    BK_WRITE = 2'b01,
    BK_IO    = 2'b10,
    BK_RDWR  = 2'b11
  } bkType_e;

  // strobes from control to datapath
  typedef struct packed {
    logic commitStat;
    logic raiseExc;
  } dbgStrobe_t;

  // watch length in bytes from the 2-bit length field
  function automatic logic [3:0] lenBytes(input logic [1:0] enc);
    case (enc)
      2'b00:   lenBytes = 4'd1;
      2'b01:   lenBytes = 4'd2;
      2'b11:   lenBytes = 4'd4;
      default: lenBytes = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/dbgm_datapath.sv
module dbgm_datapath
  import dbgm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SLOTS = 4,
  localparam int SELW   = $clog2(SLOTS + 2),
  localparam int CTRL_W = 16 + 4 * SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic [SELW-1:0]  regWrSel,
  input  logic [AW-1:0]    regWrData,
  input  logic             ipValid,
  input  logic [AW-1:0]    ipAddr,
  input  logic             dataValid,
  input  logic [AW-1:0]    dataAddr,
  input  logic             dataWrite,
  input  logic [1:0]       dataSize,
  input  dbgStrobe_t       stb,
  output logic [SLOTS-1:0] hitVec,
  output logic [SLOTS-1:0] enVec,
  output logic             checkEv,
  output logic [AW-1:0]    status
);

  localparam logic [SELW-1:0] SEL_CTRL = SELW'(SLOTS);
  localparam logic [SELW-1:0] SEL_STAT = SELW'(SLOTS + 1);

  logic [AW-1:0]     slotAddr [SLOTS];
  logic [CTRL_W-1:0] ctrlReg;
  logic              swStatWr;
  logic [3:0]        accLen;

  assign swStatWr = regWrEn && (regWrSel == SEL_STAT);
  assign checkEv  = ipValid || dataValid;
  assign accLen   = 4'd1 << dataSize;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < SLOTS; j++) slotAddr[j] <= '0;
      ctrlReg <= '0;
    end else if (regWrEn) begin
      for (int j = 0; j < SLOTS; j++)
        if (regWrSel == SELW'(j)) slotAddr[j] <= regWrData;
      if (regWrSel == SEL_CTRL) ctrlReg <= regWrData[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              status <= '0;
    else if (stb.commitStat) status <= {status[AW-1:SLOTS], hitVec};
    else if (swStatWr)       status <= regWrData;
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    bkType_e       sType;
    logic [3:0]    wLen;
    logic [AW-1:0] wMask;
    logic [AW:0]   wLo, wHi, aLo, aHi;
    logic          overlap, slotHit;

    assign sType   = bkType_e'(ctrlReg[16 + 4*i +: 2]);
    assign wLen    = lenBytes(ctrlReg[18 + 4*i +: 2]);
    assign wMask   = {{(AW-4){1'b0}}, wLen - 4'd1};
    assign wLo     = {1'b0, slotAddr[i] & ~wMask};
    assign wHi     = wLo + {{(AW-3){1'b0}}, wLen};
    assign aLo     = {1'b0, dataAddr};
    assign aHi     = aLo + {{(AW-3){1'b0}}, accLen};
    assign overlap = (aLo < wHi) && (wLo < aHi);

    always_comb begin
      case (sType)
        BK_EXEC:  slotHit = ipValid && (ipAddr == slotAddr[i]);
        BK_WRITE: slotHit = dataValid && dataWrite && overlap;
        BK_RDWR:  slotHit = dataValid && overlap;
        default:  slotHit = 1'b0;
      endcase
    end

    assign hitVec[i] = slotHit;
    assign enVec[i]  = ctrlReg[2*i] | ctrlReg[2*i + 1];

    AST_IO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (sType == BK_IO) |-> !slotHit); // R4
    AST_EXEC_NEEDS_IP: assert property (@(posedge clk) disable iff (!rst_n)
      (sType == BK_EXEC && slotHit) |-> ipValid); // R3
  end

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!stb.commitStat && !swStatWr) |-> $stable(status)); // R7

endmodule

// File: rtl/dbgm_control.sv
module dbgm_control
  import dbgm_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] hitVec,
  input  logic [SLOTS-1:0] enVec,
  input  logic             checkEv,
  input  logic             forceUpd,
  output dbgStrobe_t       stb,
  output logic             dbgExc
);

  logic enHit;

  assign enHit          = |(hitVec & enVec);
  assign stb.commitStat = checkEv && (enHit || forceUpd);
  assign stb.raiseExc   = checkEv && enHit;

  always_ff @(posedge clk) begin
    if (!rst_n) dbgExc <= 1'b0;
    else        dbgExc <= stb.raiseExc;
  end

  AST_EXC_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    dbgExc |-> $past(checkEv)); // R8

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbgm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SLOTS = 4,
  localparam int SELW = $clog2(SLOTS + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            regWrEn,
  input  logic [SELW-1:0] regWrSel,
  input  logic [AW-1:0]   regWrData,
  input  logic            ipValid,
  input  logic [AW-1:0]   ipAddr,
  input  logic            dataValid,
  input  logic [AW-1:0]   dataAddr,
  input  logic            dataWrite,
  input  logic [1:0]      dataSize,
  input  logic            forceUpd,
  output logic [AW-1:0]   status,
  output logic            dbgExc
);

  dbgStrobe_t       stb;
  logic [SLOTS-1:0] hitVec, enVec;
  logic             checkEv;

  dbgm_datapath #(.AW(AW), .SLOTS(SLOTS)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .ipValid(ipValid), .ipAddr(ipAddr),
    .dataValid(dataValid), .dataAddr(dataAddr),
    .dataWrite(dataWrite), .dataSize(dataSize),
    .stb(stb), .hitVec(hitVec), .enVec(enVec),
    .checkEv(checkEv), .status(status)
  );

  dbgm_control #(.SLOTS(SLOTS)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .hitVec(hitVec), .enVec(enVec), .checkEv(checkEv),
    .forceUpd(forceUpd), .stb(stb), .dbgExc(dbgExc)
  );

  AST_EXC_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    dbgExc |-> (status[SLOTS-1:0] != '0)); // R6

endmodule

// File: tb/tb_dbg_match_unit.sv
`timescale 1ns/1ps
module tb_dbg_match_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrSel = '0;
  logic [31:0] regWrData = '0;
  logic        ipValid = 1'b0;
  logic [31:0] ipAddr = '0;
  logic        dataValid = 1'b0;
  logic [31:0] dataAddr = '0;
  logic        dataWrite = 1'b0;
  logic [1:0]  dataSize = '0;
  logic        forceUpd = 1'b0;
  logic [31:0] status;
  logic        dbgExc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mAddr [4];
  logic [31:0] mCtrl = '0;
  logic [31:0] mStat = '0;

  always #2 clk = ~clk;

  dbg_match_unit dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .ipValid(ipValid), .ipAddr(ipAddr),
    .dataValid(dataValid), .dataAddr(dataAddr), .dataWrite(dataWrite),
    .dataSize(dataSize), .forceUpd(forceUpd), .status(status), .dbgExc(dbgExc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint lenOf(input logic [1:0] e);
    case (e)
      2'b00: return 1;
      2'b01: return 2;
      2'b11: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic bit slotHit(input int n, input logic ipV, input logic [31:0] ip,
                                 input logic dV, input logic [31:0] dA,
                                 input logic dW, input logic [1:0] dS);
    logic [1:0] t = mCtrl[16+4*n +: 2];
    longint L = lenOf(mCtrl[18+4*n +: 2]);
    longint S = longint'(1) << dS;
    longint wb = longint'(mAddr[n]) - (longint'(mAddr[n]) % L);
    longint a = longint'(dA);
    bit ov = (a < wb + L) && (wb < a + S);
    case (t)
      2'b00: return ipV && (ip == mAddr[n]);
      2'b01: return dV && dW && ov;
      2'b11: return dV && ov;
      default: return 0;
    endcase
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (sel < 4) mAddr[sel] = d;
    else if (sel == 4) mCtrl = d;
    else if (sel == 5) mStat = d;
  endtask

  task automatic acc(input string req, input logic ipV, input logic [31:0] ip,
                     input logic dV, input logic [31:0] dA, input logic dW,
                     input logic [1:0] dS, input logic frc,
                     input logic sw, input logic [31:0] swVal);
    logic [3:0] hits, en;
    logic enHit, commit;
    logic [31:0] expStat;
    for (int n = 0; n < 4; n++) begin
      hits[n] = slotHit(n, ipV, ip, dV, dA, dW, dS);
      en[n]   = mCtrl[2*n] | mCtrl[2*n+1];
    end
    enHit  = |(hits & en);
    commit = (ipV || dV) && (enHit || frc);
    expStat = commit ? {mStat[31:4], hits} : (sw ? swVal : mStat);
    @(negedge clk);
    ipValid = ipV; ipAddr = ip; dataValid = dV; dataAddr = dA;
    dataWrite = dW; dataSize = dS; forceUpd = frc;
    regWrEn = sw; regWrSel = 3'd5; regWrData = swVal;
    @(negedge clk);
    ipValid = 0; dataValid = 0; forceUpd = 0; regWrEn = 0;
    chk({req, " status"}, status, expStat);
    chk({req, " dbgExc"}, {31'd0, dbgExc}, {31'd0, (ipV || dV) && enHit});
    mStat = expStat;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 4; n++) mAddr[n] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 32'd0);
    chk("R1 reset exc", {31'd0, dbgExc}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset status", status, 32'd0);
    chk("R1 after reset exc", {31'd0, dbgExc}, 32'd0);

    // R2 register loads, status readback
    for (int n = 0; n < 4; n++) wr(3'(n), 32'h1000 + 32'(16*n));
    wr(3'd5, 32'h0000_0A00);
    chk("R2 status write", status, 32'h0000_0A00);

    // R3 / R9: execute matches under every enable combination
    for (int n = 0; n < 4; n++) begin
      for (int e = 0; e < 4; e++) begin
        wr(3'd4, 32'(e) << (2*n));
        acc("R3 R9 exec hit", 1, mAddr[n], 0, 0, 0, 0, 0, 0, 0);
        acc("R3 exec near miss", 1, mAddr[n] + 1, 0, 0, 0, 0, 0, 0, 0);
        acc("R3 ip invalid", 0, mAddr[n], 0, 0, 0, 0, 0, 0, 0);
      end
    end

    // R4: type codes on slot 2 against reads, writes and pointers
    wr(3'd2, 32'h300);
    for (int t = 0; t < 4; t++) begin
      wr(3'd4, (32'd1 << 5) | (32'(t) << 24));
      acc("R4 read access", 0, 0, 1, 32'h300, 0, 0, 0, 0, 0);
      acc("R4 write access", 0, 0, 1, 32'h300, 1, 0, 0, 0, 0);
      acc("R4 pointer", 1, 32'h300, 0, 0, 0, 0, 0, 0, 0);
    end

    // R5: overlap sweep on slot 1, every length and size
    wr(3'd1, 32'h203);
    for (int l = 0; l < 4; l++) begin
      wr(3'd4, (32'd1 << 2) | (32'd3 << 20) | (32'(l) << 22));
      for (int a = 32'h1F8; a <= 32'h212; a++)
        for (int s = 0; s < 4; s++)
          acc("R5 overlap", 0, 0, 1, 32'(a), 1, 2'(s), 0, 0, 0);
    end

    // R6 / R7: disabled hits, forced commit, mixed hits
    wr(3'd0, 32'h400);
    wr(3'd3, 32'h400);
    wr(3'd4, 32'd0);
    wr(3'd5, 32'h0);
    acc("R7 disabled hit no force", 1, 32'h400, 0, 0, 0, 0, 0, 0, 0);
    acc("R7 disabled hit forced", 1, 32'h400, 0, 0, 0, 0, 1, 0, 0);
    acc("R7 force no hit", 1, 32'h999, 0, 0, 0, 0, 1, 0, 0);
    acc("R7 force without check", 0, 32'h400, 0, 0, 0, 0, 1, 0, 0);
    wr(3'd4, 32'd1);
    acc("R6 mixed enabled and disabled", 1, 32'h400, 0, 0, 0, 0, 0, 0, 0);

    // R6: upper status bits kept through a commit
    wr(3'd5, 32'hABCD_0005);
    chk("R2 status load", status, 32'hABCD_0005);
    acc("R6 upper bits kept", 1, 32'h400, 0, 0, 0, 0, 0, 0, 0);

    // R2: commit beats a colliding status write; lone write lands
    acc("R2 commit wins", 1, 32'h400, 0, 0, 0, 0, 0, 1, 32'h1111_0000);
    acc("R2 write without commit", 1, 32'h777, 0, 0, 0, 0, 0, 1, 32'h2222_0000);

    // R8: pulse is a single cycle
    acc("R8 exc raise", 1, 32'h400, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R8 exc drops", {31'd0, dbgExc}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule